// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is a four-wire SPI target that lets an external host read and write a 128-entry space of byte-wide registers. SCLK, chip select and serial input are brought into the system clock domain through synchronizer flops, and all protocol handling runs on the system clock. The system clock must run several times faster than SCLK: eight or more system cycles per SCLK half-period covers the synchronizer and pipeline delays.

Each transaction opens with chip select going low and a command byte. The command byte carries a read flag and a register address. One or more data bytes follow. In a burst the address steps after every data byte. The register storage lives outside the block and is reached through a single-address port. The block watches its own writes to hold one control bit, which switches off a companion I2C decoder that shares the same pins.

Top module: `spi_regslave`

## Requirements
- R1: Bits travel MSB first. The first byte after chip select falls is the command: bit 7 set means read and clear means write, and bits 6:0 are the starting register address.
- R2: A write byte is committed only after all 8 of its bits are in. It appears as a one-cycle `reg_wr_en` pulse with `reg_addr` and `reg_wdata`, and a read strobe never occurs in the same cycle.
- R3: For a read, `reg_rd_en` pulses with `reg_addr` as soon as the last command bit arrives, and `reg_rdata` is taken in that same cycle. The byte is driven on `spi_sdo` MSB first, changing on SCLK falling edges, starting at the first falling edge after the command byte.
- R4: In a burst, the address increments after each data byte and wraps from 0x7F to 0x00, for reads and for writes.
- R5: `spi_sdo_oe` is high only while chip select is low. Otherwise the output is released.
- R6: If chip select rises part-way through a byte, that byte is discarded. The next transaction starts again with a command byte.
- R7: SCLK and serial input activity while chip select is high causes no register access and no output.
- R8: Both SPI mode 0 (SCLK idle low) and mode 3 (SCLK idle high) work, with input sampled on rising edges.
- R9: A write to address 0x6A sets `i2c_off` to bit 4 of the written byte. Writes to other addresses leave it unchanged.
- R10: After reset, `spi_sdo_oe`, `reg_wr_en`, `reg_rd_en` and `i2c_off` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo |
| reg_addr | output | 7 | Register address for read or write |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd_en | output | 1 | One-cycle read strobe; reg_rdata sampled in that cycle |
| reg_rdata | input | 8 | Read data for reg_addr |
| i2c_off | output | 1 | Disables the companion I2C decoder |

## Verification
A bit counter out of step shows up within one byte. Either a write reaches the register port with a shifted address or data, or read data arrives rotated on `spi_sdo`. Address stepping faults only appear in later bytes of a burst, so long bursts across the 0x7F boundary in both modes expose them, and a full 128-byte sweep touches every address. State left over from an aborted byte or from clocks seen while deselected becomes visible in the very next transaction, as a stray write or a misread command.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic                is_read;
        logic [CNT_W-1:0]    bit_cnt;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   wr_addr;
        logic [BYTE_W-1:0]   rx_sh;
        logic [BYTE_W-1:0]   tx_sh;
        logic [BYTE_W-1:0]   wr_data;
        logic                sdo;
        logic                oe;
        logic                wr_en;
        logic                rd_en;
        logic                sclk_prev;
    } ctrl_state_t;

endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = din;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_rs_ctrl.sv
module spi_rs_ctrl
    import spi_regslave_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              sdi_s,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd_en,
    input  logic [BYTE_W-1:0] reg_rdata
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    ctrl_state_t st_d, st_q;
    logic        cs_act;
    logic        rise;
    logic        fall;
    logic [BYTE_W-1:0] rx_byte;

    assign cs_act = ~cs_n_s;
    assign rise   = sclk_s & ~st_q.sclk_prev;
    assign fall   = ~sclk_s & st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.wr_en     = 1'b0;
        st_d.rd_en     = 1'b0;
        st_d.sclk_prev = sclk_s;
        st_d.oe        = cs_act;
        rx_byte        = {st_q.rx_sh[BYTE_W-2:0], sdi_s};

        if (!cs_act) begin
            st_d.phase   = PH_CMD;
            st_d.is_read = 1'b0;
            st_d.bit_cnt = '0;
            st_d.tx_sh   = '0;
            st_d.sdo     = 1'b0;
        end else begin
            if (rise) begin
                st_d.rx_sh   = rx_byte;
                st_d.bit_cnt = st_q.bit_cnt + CNT_W'(1);
                if (st_q.bit_cnt == LAST_BIT) begin
                    if (st_q.phase == PH_CMD) begin
                        st_d.phase   = PH_DATA;
                        st_d.is_read = rx_byte[BYTE_W-1];
                        st_d.addr    = rx_byte[ADDR_W-1:0];
                        st_d.rd_en   = rx_byte[BYTE_W-1];
                    end else if (st_q.is_read) begin
                        st_d.addr  = st_q.addr + ADDR_W'(1);
                        st_d.rd_en = 1'b1;
                    end else begin
                        st_d.wr_en   = 1'b1;
                        st_d.wr_addr = st_q.addr;
                        st_d.wr_data = rx_byte;
                        st_d.addr    = st_q.addr + ADDR_W'(1);
                    end
                end
            end else if (fall) begin
                st_d.sdo   = st_q.tx_sh[BYTE_W-1];
                st_d.tx_sh = {st_q.tx_sh[BYTE_W-2:0], 1'b0};
            end
            if (st_q.rd_en) begin
                st_d.tx_sh = reg_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_CMD, sclk_prev: 1'b0, default: '0};
        else        st_q <= st_d;
    end

    assign sdo       = st_q.sdo;
    assign sdo_oe    = st_q.oe;
    assign reg_wr_en = st_q.wr_en;
    assign reg_rd_en = st_q.rd_en;
    assign reg_wdata = st_q.wr_data;
    assign reg_addr  = st_q.wr_en ? st_q.wr_addr : st_q.addr;

    p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |=> !st_q.wr_en);

    p_no_wr_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.wr_en && st_q.rd_en));

    p_oe_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdo_oe);

    p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (st_q.bit_cnt == '0 && st_q.phase == PH_CMD && !st_q.wr_en));

    p_wr_needs_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |-> $past(cs_act));

endmodule

// File: rtl/spi_rs_i2c_gate.sv
module spi_rs_i2c_gate
    import spi_regslave_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h6A,
    parameter int                CTRL_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              i2c_off
);

    logic off_d, off_q;
    logic hit;

    assign hit = wr_en && (wr_addr == CTRL_ADDR);

    always_comb begin
        off_d = off_q;
        if (hit) off_d = wr_data[CTRL_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= 1'b0;
        else        off_q <= off_d;
    end

    assign i2c_off = off_q;

    p_ctrl_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (i2c_off == $past(wr_data[CTRL_BIT])));

    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(i2c_off));

endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
    import spi_regslave_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 7'h6A,
    parameter int                CTRL_BIT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd_en,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              i2c_off
);

    localparam int           SYNC_W   = 3;
    localparam logic [2:0]   SYNC_RST = 3'b010;

    logic [SYNC_W-1:0] pins_raw, pins_s;

    assign pins_raw = {spi_sclk, spi_cs_n, spi_sdi};

    spi_rs_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    spi_rs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[2]),
        .cs_n_s    (pins_s[1]),
        .sdi_s     (pins_s[0]),
        .sdo       (spi_sdo),
        .sdo_oe    (spi_sdo_oe),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rd_en (reg_rd_en),
        .reg_rdata (reg_rdata)
    );

    spi_rs_i2c_gate #(
        .CTRL_ADDR (CTRL_ADDR),
        .CTRL_BIT  (CTRL_BIT)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .i2c_off (i2c_off)
    );

endmodule

// File: tb/spi_regslave_bench.sv
module spi_regslave_bench;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sdi = 1'b0;
    logic       spi_sdo, spi_sdo_oe;
    logic [6:0] reg_addr;
    logic       reg_wr_en, reg_rd_en;
    logic [7:0] reg_wdata, reg_rdata;
    logic       i2c_off;

    logic [7:0] mem [0:127];
    logic [7:0] expv [0:127];
    int         wr_cnt = 0;
    int         nchk = 0;
    int         nfail = 0;
    logic       mode3 = 1'b0;

    always #4 clk = ~clk;

    spi_regslave u_spi_regslave (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_sdi    (spi_sdi),
        .spi_sdo    (spi_sdo),
        .spi_sdo_oe (spi_sdo_oe),
        .reg_addr   (reg_addr),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .reg_rd_en  (reg_rd_en),
        .reg_rdata  (reg_rdata),
        .i2c_off    (i2c_off)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_wr_en) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'((a * 37 + salt) & 255);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic m3);
        mode3    = m3;
        spi_sclk = m3;
        wait_cyc(2 * HALF);
    endtask

    task automatic spi_begin();
        spi_cs_n = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic spi_end();
        wait_cyc(HALF);
        spi_cs_n = 1'b1;
        wait_cyc(2 * HALF);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (mode3) spi_sclk = 1'b0;
            spi_sdi = tx[i];
            wait_cyc(HALF);
            rx[i] = spi_sdo;
            spi_sclk = 1'b1;
            wait_cyc(HALF);
            if (!mode3) spi_sclk = 1'b0;
        end
    endtask

    task automatic burst_write(input logic [6:0] a0, input int n, input int salt);
        logic [7:0] rx;
        spi_begin();
        spi_bits({1'b0, a0}, 8, rx);
        for (int k = 0; k < n; k++) begin
            spi_bits(pat(k + int'(a0), salt), 8, rx);
            expv[7'(a0 + 7'(k))] = pat(k + int'(a0), salt);
        end
        spi_end();
    endtask

    task automatic burst_read(input logic [6:0] a0, input int n, input string req);
        logic [7:0] rx;
        spi_begin();
        spi_bits({1'b1, a0}, 8, rx);
        for (int k = 0; k < n; k++) begin
            spi_bits(8'h00, 8, rx);
            check(req, rx, expv[7'(a0 + 7'(k))]);
        end
        spi_end();
    endtask

    task automatic write_one(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] rx;
        spi_begin();
        spi_bits({1'b0, a}, 8, rx);
        spi_bits(d, 8, rx);
        spi_end();
        expv[a] = d;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual %h expected %h", 8'h00, 8'h01);
        summary();
        $finish;
    end

    initial begin
        int wbase;
        logic [7:0] rx;
        wait_cyc(5);
        // R10: reset state
        check("R10 oe", {7'd0, spi_sdo_oe}, 8'h00);
        check("R10 wr", {7'd0, reg_wr_en}, 8'h00);
        check("R10 rd", {7'd0, reg_rd_en}, 8'h00);
        check("R10 i2c_off", {7'd0, i2c_off}, 8'h00);
        rst_n = 1'b1;
        set_mode(1'b0);

        // R1 R2: single write, mode 0
        wbase = wr_cnt;
        write_one(7'h15, 8'hA5);
        check("R2 single write data", mem[7'h15], 8'hA5);
        check("R2 single write count", 8'(wr_cnt - wbase), 8'd1);

        // R3 R1: single read, mode 0
        burst_read(7'h15, 1, "R3 single read");

        // R5: output enable during and after a transaction
        spi_begin();
        check("R5 oe active", {7'd0, spi_sdo_oe}, 8'h01);
        spi_bits(8'h95, 8, rx);
        check("R5 oe mid", {7'd0, spi_sdo_oe}, 8'h01);
        spi_end();
        check("R5 oe released", {7'd0, spi_sdo_oe}, 8'h00);

        // R4 R2: exhaustive burst write of all addresses, mode 0
        wbase = wr_cnt;
        burst_write(7'h00, 128, 5);
        check("R2 burst write count", 8'(wr_cnt - wbase), 8'd128);
        for (int a = 0; a < 128; a++) check("R2 R4 burst mem", mem[a], expv[a]);

        // R8 R3: full burst read, mode 3
        set_mode(1'b1);
        burst_read(7'h00, 128, "R8 R3 mode3 burst read");

        // R4: read burst wrapping, mode 0
        set_mode(1'b0);
        burst_read(7'h7C, 8, "R4 read wrap");

        // R4 R8: write burst wrapping, mode 3
        set_mode(1'b1);
        burst_write(7'h7E, 4, 91);
        check("R4 wrap 7E", mem[7'h7E], expv[7'h7E]);
        check("R4 wrap 7F", mem[7'h7F], expv[7'h7F]);
        check("R4 wrap 00", mem[7'h00], expv[7'h00]);
        check("R4 wrap 01", mem[7'h01], expv[7'h01]);
        burst_read(7'h7D, 6, "R4 R8 mode3 wrap read");

        // R6: abort mid-byte, both modes
        for (int m = 0; m < 2; m++) begin
            set_mode(m[0]);
            wbase = wr_cnt;
            spi_begin();
            spi_bits(8'h30, 8, rx);
            spi_bits(8'h11 + 8'(m), 8, rx);
            spi_bits(8'h22, 4, rx);
            spi_end();
            expv[7'h30] = 8'h11 + 8'(m);
            check("R6 first byte kept", mem[7'h30], 8'h11 + 8'(m));
            check("R6 partial dropped", mem[7'h31], expv[7'h31]);
            check("R6 write count", 8'(wr_cnt - wbase), 8'd1);
            burst_read(7'h30, 2, "R6 fresh command");
        end

        // R7: clocks and data with chip select high
        set_mode(1'b0);
        wbase = wr_cnt;
        for (int i = 0; i < 24; i++) begin
            spi_sdi  = i[1];
            spi_sclk = ~spi_sclk;
            wait_cyc(HALF);
            check("R7 oe stays off", {7'd0, spi_sdo_oe}, 8'h00);
        end
        spi_sclk = 1'b0;
        wait_cyc(2 * HALF);
        check("R7 no write", 8'(wr_cnt - wbase), 8'd0);
        burst_read(7'h10, 3, "R7 clean after idle clocks");

        // R9: control bit
        write_one(7'h6A, 8'h10);
        check("R9 set", {7'd0, i2c_off}, 8'h01);
        write_one(7'h6B, 8'h00);
        check("R9 other addr", {7'd0, i2c_off}, 8'h01);
        set_mode(1'b1);
        write_one(7'h6A, 8'hEF);
        check("R9 clear", {7'd0, i2c_off}, 8'h00);
        write_one(7'h29, 8'hFF);
        check("R9 other addr hold", {7'd0, i2c_off}, 8'h00);

        summary();
        $finish;
    end

endmodule